// File: doc/BRIEF.md
# Interworking Branch Target Unit

This block turns a raw branch target into the address the fetch unit will use next, together with the instruction-set mode that fetch should decode in. It is a single combinational stage. A branch target enters with a kind selector and the core's mode flags, and the aligned address and the updated pending compact-mode flag leave in the same cycle. The flags are the compact-encoding flag, the bytecode flag, the 64-bit flag and the compact-mode flag already pending for the next instruction. The surrounding PC state registers the result when the result handshake completes.

The kind selector chooses among three kinds of branch. A plain branch only aligns the target. An interworking branch reads the two low target bits to pick the destination instruction set. A conditional-interworking branch interworks only when the core is in its base instruction set, and otherwise behaves as a plain branch. Unpredictable target encodings resolve to one fixed, deterministic result. No fault is raised here.

The target and the result streams use valid/ready. The stage holds no storage, so `tgt_ready` follows `res_ready` and `res_valid` follows `tgt_valid`. Back-pressure therefore passes straight through. A producer must hold its target stable while `tgt_valid` is high and `tgt_ready` is low. Result fields are meaningful only while `res_valid` is high.

Top module: `ibt_unit`

## Requirements
- R1: Plain branch (kind code 0, or the reserved code 3) with `cur_wide`=1 passes the target through unchanged. A plain branch of any form leaves `pend_compact_o` equal to `pend_compact_i`.
- R2: Plain branch with `cur_wide`=0 and `pend_compact_i`=1 clears address bit 0 only.
- R3: Plain branch with `cur_wide`=0 and `pend_compact_i`=0 clears address bits 1 and 0.
- R4: Interworking branch with `cur_compact`=1 and `cur_bytecode`=1 clears bit 0 and keeps `pend_compact_i`. When bit 0 is already 0, the address is returned unmodified.
- R5: Interworking branch outside that submode with target bit 0 = 1 sets `pend_compact_o`=1 and clears bit 0.
- R6: Interworking branch outside that submode with target bits 1:0 = 00 sets `pend_compact_o`=0 and returns the address unmodified.
- R7: Interworking branch outside that submode with target bits 1:0 = 10 keeps `pend_compact_i` and clears bits 1 and 0.
- R8: Kind code 1 always interworks. Kind code 2 interworks only when `cur_compact`=0 and `cur_bytecode`=0, and is a plain branch otherwise. The interworking rules do not look at `cur_wide`.
- R9: Address bits above bit 1 always equal the target's bits.
- R10: `res_valid` equals `tgt_valid` and `tgt_ready` equals `res_ready` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tgt_valid | input | 1 | Target present |
| tgt_ready | output | 1 | Target accepted (follows res_ready) |
| tgt_addr | input | ADDR_W | Raw branch target |
| kind | input | 2 | 0 plain, 1 interworking, 2 interworking in base set only, 3 plain |
| cur_compact | input | 1 | Core currently in compact encoding |
| cur_bytecode | input | 1 | Bytecode flag |
| cur_wide | input | 1 | Core in 64-bit mode |
| pend_compact_i | input | 1 | Compact flag already pending for the next instruction |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer accepts result |
| res_addr | output | ADDR_W | Aligned next-PC |
| pend_compact_o | output | 1 | Updated pending compact flag |

## Verification
The bench builds the unit with ADDR_W=64, so the upper half of the target carries patterns that a 32-bit build never drives and R9 is checked across the full wide path. For each of three upper-bit patterns it sweeps all four low-bit values, all four kind codes and all sixteen settings of the compact, bytecode, wide and pending flags. This reaches the bytecode submode, the reserved kind code and the unpredictable 10 encoding. Valid and ready are toggled on independent rhythms during the sweep, so both directions of the pass-through are seen.

// File: rtl/ibt_pkg.sv
package ibt_pkg;
  typedef enum logic [1:0] {
    BK_PLAIN     = 2'd0,
    BK_XFER      = 2'd1,
    BK_XFER_BASE = 2'd2,
    BK_RSVD      = 2'd3
  } bkind_e;
  localparam int LOW_W = 2;
endpackage

// File: rtl/ibt_kind_resolve.sv
module ibt_kind_resolve
  import ibt_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       compact,
  input  logic       bytecode,
  output logic       do_xfer
);
  bkind_e k;
  always_comb begin
    k = bkind_e'(kind);
    case (k)
      BK_XFER:      do_xfer = 1'b1;
      BK_XFER_BASE: do_xfer = !compact && !bytecode;
      default:      do_xfer = 1'b0;
    endcase
  end

  always_comb begin
    if (kind == 2'd0 || kind == 2'd3)
      assert_plain_kind_R8: assert (!do_xfer);
  end
endmodule

// File: rtl/ibt_plain_align.sv
module ibt_plain_align #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wide,
  input  logic              pend_compact,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] KEEP_HALF = ~{{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] KEEP_WORD = ~{{(ADDR_W-2){1'b0}}, 2'b11};

  always_comb begin
    if (wide)              addr_o = addr_i;
    else if (pend_compact) addr_o = addr_i & KEEP_HALF;
    else                   addr_o = addr_i & KEEP_WORD;
  end

  always_comb begin
    if (wide) assert_wide_pass_R1: assert (addr_o == addr_i);
    if (!wide && !pend_compact) assert_word_align_R3: assert (addr_o[1:0] == 2'b00);
  end
endmodule

// File: rtl/ibt_xfer_decode.sv
module ibt_xfer_decode #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ext_sub,
  input  logic              pend_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pend_o
);
  localparam int HI = ADDR_W - 1;

  always_comb begin
    addr_o = addr_i;
    pend_o = pend_i;
    if (ext_sub) begin
      addr_o[0] = 1'b0;
    end else begin
      unique case (addr_i[1:0])
        2'b01, 2'b11: begin pend_o = 1'b1; addr_o[0] = 1'b0; end
        2'b00:        pend_o = 1'b0;
        default:      addr_o[1:0] = 2'b00;
      endcase
    end
  end

  always_comb begin
    if (!ext_sub && addr_i[0])
      assert_to_compact_R5: assert (pend_o && !addr_o[0]);
    if (!ext_sub && addr_i[1:0] == 2'b00)
      assert_to_base_R6: assert (!pend_o && addr_o == addr_i);
    if (ext_sub)
      assert_ext_keep_R4: assert (pend_o == pend_i && addr_o[HI:1] == addr_i[HI:1]);
  end
endmodule

// File: rtl/ibt_unit.sv
module ibt_unit #(
  parameter int ADDR_W = 32
) (
  input  logic              tgt_valid,
  output logic              tgt_ready,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [1:0]        kind,
  input  logic              cur_compact,
  input  logic              cur_bytecode,
  input  logic              cur_wide,
  input  logic              pend_compact_i,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_addr,
  output logic              pend_compact_o
);
  import ibt_pkg::*;
  localparam int HI = ADDR_W - 1;

  logic              do_xfer;
  logic              ext_sub;
  logic [ADDR_W-1:0] plain_addr;
  logic [ADDR_W-1:0] xfer_addr;
  logic              xfer_pend;

  assign ext_sub = cur_compact && cur_bytecode;

  ibt_kind_resolve u_kind (
    .kind     (kind),
    .compact  (cur_compact),
    .bytecode (cur_bytecode),
    .do_xfer  (do_xfer)
  );

  ibt_plain_align #(.ADDR_W(ADDR_W)) u_plain (
    .addr_i       (tgt_addr),
    .wide         (cur_wide),
    .pend_compact (pend_compact_i),
    .addr_o       (plain_addr)
  );

  ibt_xfer_decode #(.ADDR_W(ADDR_W)) u_xfer (
    .addr_i (tgt_addr),
    .ext_sub(ext_sub),
    .pend_i (pend_compact_i),
    .addr_o (xfer_addr),
    .pend_o (xfer_pend)
  );

  always_comb begin
    if (do_xfer) begin
      res_addr       = xfer_addr;
      pend_compact_o = xfer_pend;
    end else begin
      res_addr       = plain_addr;
      pend_compact_o = pend_compact_i;
    end
  end

  assign res_valid = tgt_valid;
  assign tgt_ready = res_ready;

  always_comb begin
    assert_high_bits_R9: assert (res_addr[HI:LOW_W] == tgt_addr[HI:LOW_W]);
    if (!do_xfer)
      assert_plain_pend_R1: assert (pend_compact_o == pend_compact_i);
  end
endmodule

// File: tb/ibt_unit_bench.sv
module ibt_unit_bench;
  localparam int AW = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          tgt_valid, tgt_ready, res_valid, res_ready;
  logic [AW-1:0] tgt_addr, res_addr;
  logic [1:0]    kind;
  logic          cur_compact, cur_bytecode, cur_wide, pend_compact_i, pend_compact_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  ibt_unit #(.ADDR_W(AW)) u_ibt_unit (
    .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_addr(tgt_addr),
    .kind(kind), .cur_compact(cur_compact), .cur_bytecode(cur_bytecode),
    .cur_wide(cur_wide), .pend_compact_i(pend_compact_i),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_addr(res_addr), .pend_compact_o(pend_compact_o)
  );

  // Behavioural reference: arithmetic on the low two bits as an integer.
  function automatic void model(input logic [AW-1:0] a, input int k, input bit c,
                                input bit b, input bit w, input bit p,
                                output logic [AW-1:0] ea, output bit ep,
                                output string req);
    int  lo = int'(a[1:0]);
    bit  xfer = (k == 1) || (k == 2 && !c && !b);
    logic [AW-1:0] base = a - AW'(lo);
    ep = p;
    if (!xfer) begin
      if (w)      begin ea = a; req = "R1"; end
      else if (p) begin ea = base + AW'(lo & 2); req = "R2"; end
      else        begin ea = base; req = "R3"; end
      if (k == 2 || k == 3) req = {req, "/R8"};
    end else if (c && b) begin
      ea = base + AW'(lo & 2); req = "R4";
    end else if (lo % 2 == 1) begin
      ea = base + AW'(lo & 2); ep = 1; req = "R5";
    end else if (lo == 0) begin
      ea = a; ep = 0; req = "R6";
    end else begin
      ea = base; req = "R7";
    end
    if (k == 2) req = {req, "/R8"};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [AW-1:0] hi_pat [3];
    logic [AW-1:0] ea;
    bit            ep;
    string         req;
    int            n = 0;
    hi_pat[0] = 64'h0000_0000_0000_0000;
    hi_pat[1] = 64'hDEAD_BEEF_1234_5678;
    hi_pat[2] = 64'hFFFF_FFFF_FFFF_FFFC;
    tgt_valid = 0; res_ready = 0; tgt_addr = '0; kind = 0;
    cur_compact = 0; cur_bytecode = 0; cur_wide = 0; pend_compact_i = 0;
    @(negedge clk);
    check(res_valid == 1'b0, "R10", "idle res_valid", AW'(res_valid), 0);
    check(tgt_ready == 1'b0, "R10", "idle tgt_ready", AW'(tgt_ready), 0);
    for (int h = 0; h < 3; h++) begin
      for (int fl = 0; fl < 16; fl++) begin
        for (int k = 0; k < 4; k++) begin
          for (int lo = 0; lo < 4; lo++) begin
            @(posedge clk); #1;
            tgt_addr       = (hi_pat[h] & ~AW'(3)) | AW'(lo);
            kind           = 2'(k);
            cur_compact    = fl[0];
            cur_bytecode   = fl[1];
            cur_wide       = fl[2];
            pend_compact_i = fl[3];
            tgt_valid      = (n % 5) != 0;
            res_ready      = (n % 3) != 1;
            n++;
            @(negedge clk);
            model(tgt_addr, k, fl[0], fl[1], fl[2], fl[3], ea, ep, req);
            check(res_addr == ea, req, "address", res_addr, ea);
            check(pend_compact_o == ep, req, "pending compact",
                  AW'(pend_compact_o), AW'(ep));
            check(res_addr[AW-1:2] == tgt_addr[AW-1:2], "R9", "upper bits",
                  res_addr, tgt_addr);
            check(res_valid == tgt_valid && tgt_ready == res_ready, "R10",
                  "handshake", AW'({res_valid, tgt_ready}), AW'({tgt_valid, res_ready}));
          end
        end
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule